// File: doc/BRIEF.md
# Panel Line and Gate Timing Generator

This block produces the raster timing for an electrophoretic panel. A divider derives a source-clock tick from a pixel-rate clock enable, and that tick drives a horizontal position counter. Each time a line ends, a vertical line counter advances. The two counters and a set of programmed lengths are decoded into the panel-facing strobes:

- line sync and frame sync;
- the horizontal and vertical active windows;
- a source-driver chip-enable window;
- a gate-driver clock pulse at programmable points inside each line;
- column and row indices that can be mirrored for reversed scan directions.

The block also emits a one-cycle end-of-frame pulse and a one-cycle line-flag pulse for a chosen line.

The horizontal lengths are sync, begin, data and end, counted in source clocks. The vertical lengths are the same four, counted in lines. Every timing input is used live. Software is expected to change the lengths only while the block is held in reset or while the pixel enable is low. No pixel data passes through the block, so it has no streaming interface and every pin is a plain control or status signal.

Top module: `epd_line_gate_timing`

## Requirements
- R1: With `wide_bus`=0 a source tick occurs on every 4th cycle in which `pix_ce` is high, and with `wide_bus`=1 on every 8th. `src_clk` is high during the first half of each such period, that is, for divider phases 0..1 (narrow) or 0..3 (wide).
- R2: `h_count` advances on each source tick and returns to 0 after the value htotal-1, where htotal = sync + begin + data + end horizontal lengths. `v_count` advances once per line wrap and returns to 0 after vtotal-1, where vtotal is the sum of the four vertical lengths.
- R3: `line_sync` is high exactly while `h_count` < `h_sync_len`. `frame_sync` is high exactly while `v_count` < `v_sync_len`.
- R4: `h_active` is high for `h_count` in [hs+hb, hs+hb+hd). `v_active` is high for `v_count` in [vs+vb, vs+vb+vd). `data_en` is their AND. The horizontal sync length must be at least 1.
- R5: `sdce` is high when `v_active` is high and `h_count` is in [hs+hb, hs+hb+`sdce_width`).
- R6: `gate_clk` is high on every line for `h_count` in [hs+`gate_start_ofs`, hs+`gate_start_ofs`+`gate_on_len`). Both edges are measured from the start of line sync.
- R7: `col_index` is `h_count`-(hs+hb) inside the horizontal active window, or hd-1 minus that offset when `source_reverse`=1. It is 0 outside the window.
- R8: `row_index` is `v_count`-(vs+vb) inside the vertical active window, or vd-1 minus that offset when `gate_reverse`=1. It is 0 outside the window.
- R9: `frame_end` is high for exactly the one cycle after the tick on which both counters wrap.
- R10: `line_flag` is high for exactly the one cycle after the tick that ends line `line_flag_num`.
- R11: In reset, the counters, the divider phase and both pulses are 0. A cycle with `pix_ce` low changes neither the counters nor the divider phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel-rate clock enable |
| wide_bus | input | 1 | 0: 8-bit source bus (divide by 4), 1: 16-bit (divide by 8) |
| h_sync_len | input | 8 | Line sync length in source clocks |
| h_begin_len | input | 12 | Line begin (back porch) length |
| h_data_len | input | 12 | Line data length |
| h_end_len | input | 12 | Line end (front porch) length |
| v_sync_len | input | 8 | Frame sync length in lines |
| v_begin_len | input | 11 | Frame begin length in lines |
| v_data_len | input | 11 | Active line count |
| v_end_len | input | 11 | Frame end length in lines |
| gate_start_ofs | input | 8 | Gate clock rise offset after sync length |
| gate_on_len | input | 12 | Gate clock high length |
| sdce_width | input | 10 | Source chip-enable width |
| line_flag_num | input | 11 | Line that raises the line flag |
| gate_reverse | input | 1 | Mirror row index (bottom to top) |
| source_reverse | input | 1 | Mirror column index (right to left) |
| src_clk | output | 1 | Divided source clock |
| h_count | output | 12 | Horizontal position |
| v_count | output | 11 | Line number |
| line_sync | output | 1 | Line sync |
| frame_sync | output | 1 | Frame sync |
| h_active | output | 1 | Horizontal active window |
| v_active | output | 1 | Vertical active window |
| data_en | output | 1 | Both windows active |
| sdce | output | 1 | Source chip-enable window |
| gate_clk | output | 1 | Gate-driver clock |
| col_index | output | 12 | Column inside active area |
| row_index | output | 11 | Row inside active area |
| frame_end | output | 1 | One-cycle end-of-frame pulse |
| line_flag | output | 1 | One-cycle flagged-line pulse |

## Verification
Every output is a function of three state variables: the divider phase, the horizontal position and the line number. A wrong phase shows up within one source period, either as a skewed `src_clk` or as an early or late step of `h_count`. A wrong horizontal position shows up within a single tick, because it misplaces the sync, window, chip-enable and gate edges. A wrong line number can go unnoticed until the next line boundary, or until the frame pulse, where the line flag and the end-of-frame pulse land on the wrong tick. The bench therefore compares every output on every cycle over whole frames, in both bus widths, with both mirror settings and with a gapped pixel enable.

// File: rtl/epd_timing_pkg.sv
package epd_timing_pkg;

  // Divider settings for the two source bus widths.
  localparam int NARROW_DIV = 3;
  localparam int WIDE_DIV   = 7;

  // Half-open interval test on unsigned positions.
  function automatic logic in_span(input logic [15:0] pos,
                                   input logic [15:0] lo,
                                   input logic [15:0] hi);
    return (pos >= lo) && (pos < hi);
  endfunction

endpackage

// File: rtl/epd_sclk_div.sv
module epd_sclk_div #(
  parameter int DW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_ce,
  input  logic wide_bus,
  output logic tick,
  output logic src_clk
);
  import epd_timing_pkg::*;

  localparam logic [DW-1:0] DIV_N = DW'(NARROW_DIV);
  localparam logic [DW-1:0] DIV_W = DW'(WIDE_DIV);

  logic [DW-1:0] phase_q;
  logic [DW-1:0] limit;
  logic [DW-1:0] half;

  assign limit = wide_bus ? DIV_W : DIV_N;
  assign half  = wide_bus ? DW'((WIDE_DIV + 1) / 2) : DW'((NARROW_DIV + 1) / 2);

  assign tick    = pix_ce && (phase_q >= limit);
  assign src_clk = phase_q < half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (tick)   phase_q <= '0;
    else if (pix_ce) phase_q <= phase_q + 1'b1;
  end

  // R11
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> $stable(phase_q));

endmodule

// File: rtl/epd_axis_counter.sv
module epd_axis_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] last_pos;

  assign last_pos = total - 1'b1;
  assign wrap     = step && (cnt >= last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  // R2
  cnt_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

endmodule

// File: rtl/epd_window_decode.sv
module epd_window_decode #(
  parameter int HW  = 12,
  parameter int VW  = 11,
  parameter int SW  = 8,
  parameter int CEW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HW-1:0]  h_cnt,
  input  logic [VW-1:0]  v_cnt,
  input  logic [SW-1:0]  hs_len,
  input  logic [HW-1:0]  hb_len,
  input  logic [HW-1:0]  hd_len,
  input  logic [SW-1:0]  vs_len,
  input  logic [VW-1:0]  vb_len,
  input  logic [VW-1:0]  vd_len,
  input  logic [SW-1:0]  gd_ofs,
  input  logic [HW-1:0]  gd_on,
  input  logic [CEW-1:0] ce_w,
  input  logic           src_rev,
  input  logic           gate_rev,
  output logic           line_sync,
  output logic           frame_sync,
  output logic           h_act,
  output logic           v_act,
  output logic           data_en,
  output logic           sdce,
  output logic           gate_clk,
  output logic [HW-1:0]  col_idx,
  output logic [VW-1:0]  row_idx
);
  import epd_timing_pkg::*;

  logic [HW-1:0] hact_last_blank;
  logic [HW-1:0] hact_end;
  logic [HW-1:0] h_off;
  logic [HW-1:0] g_rise;
  logic [HW-1:0] g_fall;
  logic [VW-1:0] vact_st;
  logic [VW-1:0] vact_end;
  logic [VW-1:0] v_off;

  // Horizontal window: the start point is the last blank position.
  assign hact_last_blank = HW'(hs_len) + hb_len - 1'b1;
  assign hact_end        = HW'(hs_len) + hb_len + hd_len;
  assign h_off           = h_cnt - hact_last_blank - 1'b1;
  assign h_act           = (h_cnt > hact_last_blank) && (h_cnt < hact_end);

  assign vact_st  = VW'(vs_len) + vb_len;
  assign vact_end = vact_st + vd_len;
  assign v_off    = v_cnt - vact_st;
  assign v_act    = in_span(16'(v_cnt), 16'(vact_st), 16'(vact_end));

  assign line_sync  = h_cnt < HW'(hs_len);
  assign frame_sync = v_cnt < VW'(vs_len);
  assign data_en    = h_act && v_act;

  assign sdce = v_act && (h_cnt > hact_last_blank) && (h_off < HW'(ce_w));

  // Gate pulse edges counted from the start of line sync.
  assign g_rise   = HW'(hs_len) + HW'(gd_ofs);
  assign g_fall   = g_rise + gd_on;
  assign gate_clk = in_span(16'(h_cnt), 16'(g_rise), 16'(g_fall));

  always_comb begin
    col_idx = '0;
    if (h_act) col_idx = src_rev ? (hd_len - 1'b1 - h_off) : h_off;
    row_idx = '0;
    if (v_act) row_idx = gate_rev ? (vd_len - 1'b1 - v_off) : v_off;
  end

  // R5
  sdce_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdce |-> v_act);
  // R7
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_act |-> (col_idx < hd_len));
  // R8
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_act |-> (row_idx < vd_len));

endmodule

// File: rtl/epd_line_gate_timing.sv
module epd_line_gate_timing #(
  parameter int HW  = 12,
  parameter int VW  = 11,
  parameter int SW  = 8,
  parameter int CEW = 10,
  parameter int DW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_ce,
  input  logic           wide_bus,
  input  logic [SW-1:0]  h_sync_len,
  input  logic [HW-1:0]  h_begin_len,
  input  logic [HW-1:0]  h_data_len,
  input  logic [HW-1:0]  h_end_len,
  input  logic [SW-1:0]  v_sync_len,
  input  logic [VW-1:0]  v_begin_len,
  input  logic [VW-1:0]  v_data_len,
  input  logic [VW-1:0]  v_end_len,
  input  logic [SW-1:0]  gate_start_ofs,
  input  logic [HW-1:0]  gate_on_len,
  input  logic [CEW-1:0] sdce_width,
  input  logic [VW-1:0]  line_flag_num,
  input  logic           gate_reverse,
  input  logic           source_reverse,
  output logic           src_clk,
  output logic [HW-1:0]  h_count,
  output logic [VW-1:0]  v_count,
  output logic           line_sync,
  output logic           frame_sync,
  output logic           h_active,
  output logic           v_active,
  output logic           data_en,
  output logic           sdce,
  output logic           gate_clk,
  output logic [HW-1:0]  col_index,
  output logic [VW-1:0]  row_index,
  output logic           frame_end,
  output logic           line_flag
);
  logic          tick;
  logic          h_wrap;
  logic          v_wrap;
  logic [HW-1:0] h_total;
  logic [VW-1:0] v_total;

  assign h_total = HW'(h_sync_len) + h_begin_len + h_data_len + h_end_len;
  assign v_total = VW'(v_sync_len) + v_begin_len + v_data_len + v_end_len;

  epd_sclk_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .wide_bus(wide_bus),
    .tick(tick), .src_clk(src_clk)
  );

  epd_axis_counter #(.W(HW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .step(tick), .total(h_total),
    .cnt(h_count), .wrap(h_wrap)
  );

  epd_axis_counter #(.W(VW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .step(h_wrap), .total(v_total),
    .cnt(v_count), .wrap(v_wrap)
  );

  epd_window_decode #(.HW(HW), .VW(VW), .SW(SW), .CEW(CEW)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .h_cnt(h_count), .v_cnt(v_count),
    .hs_len(h_sync_len), .hb_len(h_begin_len), .hd_len(h_data_len),
    .vs_len(v_sync_len), .vb_len(v_begin_len), .vd_len(v_data_len),
    .gd_ofs(gate_start_ofs), .gd_on(gate_on_len), .ce_w(sdce_width),
    .src_rev(source_reverse), .gate_rev(gate_reverse),
    .line_sync(line_sync), .frame_sync(frame_sync),
    .h_act(h_active), .v_act(v_active), .data_en(data_en),
    .sdce(sdce), .gate_clk(gate_clk),
    .col_idx(col_index), .row_idx(row_index)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_end <= 1'b0;
      line_flag <= 1'b0;
    end else begin
      frame_end <= v_wrap;
      line_flag <= h_wrap && (v_count == line_flag_num);
    end
  end

  // R2
  v_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(v_count) |-> (h_count == '0));
  // R9
  frame_end_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (h_count == '0) && (v_count == '0));
  // R9
  frame_end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
  // R10
  line_flag_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_flag |-> (h_count == '0));
  // R11
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> $stable(h_count) && $stable(v_count));

endmodule

// File: tb/epd_line_gate_timing_tb_top.sv
module epd_line_gate_timing_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic pix_ce = 1'b0, wide_bus = 1'b0;
  logic [7:0]  h_sync_len = 8'd2, v_sync_len = 8'd1, gate_start_ofs = 8'd1;
  logic [11:0] h_begin_len = 12'd3, h_data_len = 12'd8, h_end_len = 12'd2, gate_on_len = 12'd4;
  logic [10:0] v_begin_len = 11'd2, v_data_len = 11'd4, v_end_len = 11'd1, line_flag_num = 11'd3;
  logic [9:0]  sdce_width = 10'd6;
  logic gate_reverse = 1'b0, source_reverse = 1'b0;

  logic src_clk, line_sync, frame_sync, h_active, v_active, data_en, sdce, gate_clk;
  logic frame_end, line_flag;
  logic [11:0] h_count, col_index;
  logic [10:0] v_count, row_index;

  epd_line_gate_timing dut_i (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .wide_bus(wide_bus),
    .h_sync_len(h_sync_len), .h_begin_len(h_begin_len), .h_data_len(h_data_len),
    .h_end_len(h_end_len), .v_sync_len(v_sync_len), .v_begin_len(v_begin_len),
    .v_data_len(v_data_len), .v_end_len(v_end_len), .gate_start_ofs(gate_start_ofs),
    .gate_on_len(gate_on_len), .sdce_width(sdce_width), .line_flag_num(line_flag_num),
    .gate_reverse(gate_reverse), .source_reverse(source_reverse),
    .src_clk(src_clk), .h_count(h_count), .v_count(v_count),
    .line_sync(line_sync), .frame_sync(frame_sync), .h_active(h_active),
    .v_active(v_active), .data_en(data_en), .sdce(sdce), .gate_clk(gate_clk),
    .col_index(col_index), .row_index(row_index),
    .frame_end(frame_end), .line_flag(line_flag)
  );

  typedef struct {
    int sclk, h, v, ls, fs, ha, va, de, ce, gc, col, row, fe, lf;
  } exp_t;

  exp_t exp_q[$];
  int compared = 0, mismatched = 0, fe_seen = 0, fe_model = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Reference model: independent counters built from the requirements.
  int mdiv = 0, mh = 0, mv = 0, mfe = 0, mlf = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mdiv = 0; mh = 0; mv = 0; mfe = 0; mlf = 0;
    end else begin
      int dv, ht, vt, hst, vst, hd, vd, rise;
      bit tk, hw, vw;
      exp_t e;
      dv = wide_bus ? 7 : 3;
      ht = h_sync_len + h_begin_len + h_data_len + h_end_len;
      vt = v_sync_len + v_begin_len + v_data_len + v_end_len;
      tk = pix_ce && (mdiv == dv);
      hw = tk && (mh == ht - 1);
      vw = hw && (mv == vt - 1);
      mfe = vw;
      mlf = hw && (mv == line_flag_num);
      if (vw) fe_model++;
      if (pix_ce) mdiv = tk ? 0 : mdiv + 1;
      if (tk) mh = hw ? 0 : mh + 1;
      if (hw) mv = vw ? 0 : mv + 1;
      hst = h_sync_len + h_begin_len; hd = h_data_len;
      vst = v_sync_len + v_begin_len; vd = v_data_len;
      rise = h_sync_len + gate_start_ofs;
      e.sclk = (mdiv < (dv + 1) / 2);
      e.h = mh; e.v = mv;
      e.ls = (mh < h_sync_len); e.fs = (mv < v_sync_len);
      e.ha = (mh >= hst) && (mh < hst + hd);
      e.va = (mv >= vst) && (mv < vst + vd);
      e.de = e.ha && e.va;
      e.ce = e.va && (mh >= hst) && (mh < hst + sdce_width);
      e.gc = (mh >= rise) && (mh < rise + gate_on_len);
      e.col = e.ha ? (source_reverse ? hd - 1 - (mh - hst) : mh - hst) : 0;
      e.row = e.va ? (gate_reverse ? vd - 1 - (mv - vst) : mv - vst) : 0;
      e.fe = mfe; e.lf = mlf;
      exp_q.push_back(e);
    end
  end

  // Monitor: pops one expected item per cycle and compares every output.
  always @(negedge clk) begin
    if (!done && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (frame_end) fe_seen++;
      check(int'(src_clk) == e.sclk, "R1 src_clk", src_clk, e.sclk);
      check(int'(h_count) == e.h, "R2 h_count", h_count, e.h);
      check(int'(v_count) == e.v, "R2 v_count", v_count, e.v);
      check(int'(line_sync) == e.ls, "R3 line_sync", line_sync, e.ls);
      check(int'(frame_sync) == e.fs, "R3 frame_sync", frame_sync, e.fs);
      check(int'(h_active) == e.ha, "R4 h_active", h_active, e.ha);
      check(int'(v_active) == e.va, "R4 v_active", v_active, e.va);
      check(int'(data_en) == e.de, "R4 data_en", data_en, e.de);
      check(int'(sdce) == e.ce, "R5 sdce", sdce, e.ce);
      check(int'(gate_clk) == e.gc, "R6 gate_clk", gate_clk, e.gc);
      check(int'(col_index) == e.col, "R7 col_index", col_index, e.col);
      check(int'(row_index) == e.row, "R8 row_index", row_index, e.row);
      check(int'(frame_end) == e.fe, "R9 frame_end", frame_end, e.fe);
      check(int'(line_flag) == e.lf, "R10 line_flag", line_flag, e.lf);
    end
  end

  task automatic enter_reset();
    @(negedge clk); #1 rst_n = 1'b0; pix_ce = 1'b0;
    @(negedge clk); #1;
    // R11 reset state
    check(h_count == 0, "R11 reset h_count", h_count, 0);
    check(v_count == 0, "R11 reset v_count", v_count, 0);
    check(frame_end == 0, "R11 reset frame_end", frame_end, 0);
    check(line_flag == 0, "R11 reset line_flag", line_flag, 0);
    check(src_clk == 1, "R11 reset divider phase", src_clk, 1);
  endtask

  task automatic leave_reset();
    @(posedge clk); #2 rst_n = 1'b1;
  endtask

  // Gap mode 0: pix_ce always high; otherwise low on every gap-th cycle.
  task automatic run(input int cycles, input int gap);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #2;
      pix_ce = (gap == 0) ? 1'b1 : ((i % gap) != 0);
    end
    @(posedge clk); #2 pix_ce = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    // Phase A: narrow bus, no mirroring.
    enter_reset();
    leave_reset();
    run(1000, 0);

    // Phase B: wide bus, both directions mirrored, flag on line 0.
    enter_reset();
    wide_bus = 1'b1; source_reverse = 1'b1; gate_reverse = 1'b1;
    h_sync_len = 8'd1; h_begin_len = 12'd1; h_data_len = 12'd5; h_end_len = 12'd3;
    v_sync_len = 8'd2; v_begin_len = 11'd1; v_data_len = 11'd3; v_end_len = 11'd2;
    gate_start_ofs = 8'd0; gate_on_len = 12'd3; sdce_width = 10'd5; line_flag_num = 11'd0;
    leave_reset();
    run(1400, 0);

    // Phase C: gapped pixel enable, narrow bus, flag on the last line.
    enter_reset();
    wide_bus = 1'b0; gate_reverse = 1'b0; source_reverse = 1'b1;
    h_sync_len = 8'd3; h_begin_len = 12'd2; h_data_len = 12'd6; h_end_len = 12'd1;
    v_sync_len = 8'd1; v_begin_len = 11'd1; v_data_len = 11'd3; v_end_len = 11'd2;
    gate_start_ofs = 8'd2; gate_on_len = 12'd5; sdce_width = 10'd4; line_flag_num = 11'd6;
    leave_reset();
    run(1200, 3);

    @(negedge clk);
    // R9 frame pulses counted against the model over all phases
    check(fe_seen == fe_model, "R9 frame_end count", fe_seen, fe_model);
    check(fe_model >= 5, "R9 frames completed", fe_model, 5);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule